// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit keeps the eight-bit status byte of a serial nonvolatile memory and decides, one byte at a time, whether a memory write or a status write may be committed. A command decoder outside the unit sends it single-cycle strobes: set or clear the write-enable latch, a status-write request with its data byte, a memory-write request with the byte address, a mark that a write-class command was recognised, and the rising edge of chip select. The unit also samples the external write-protect pin level.

A memory write is allowed only when the write-enable latch is set and the address lies outside the block chosen by the two block-select bits. Counter-record writes are the exception: they carry a bypass flag and are always allowed. A status write also needs the latch, and it is refused when the lock bit is set while the pin is low. The latch clears by itself at the chip-select rise that ends a recognised write-class command. Each permit is combinational and valid in the same cycle as its request, so the decoder can commit or drop that byte on the same edge.

Top module: `status_guard`

## Requirements
- R1: The status byte is laid out as bit 7 = lock bit, bits 6:4 = spare writable bits, bits 3:2 = block select (bit 3 high), bit 1 = write-enable latch, and bit 0 always reads 0.
- R2: After reset the status byte is 0x00, and the write-enable latch in particular is 0.
- R3: `latchSet` sets the latch, visible from the next cycle; `latchClr` clears it; when both strobe in the same cycle the clear wins.
- R4: A permitted status write loads data bits 7:2 into the status byte from the next cycle; data bits 1:0 are ignored. A refused status write leaves the byte unchanged.
- R5: While the latch is 0, `statusWrPermit` is 0 and `memWrPermit` is 0 for every non-bypass request.
- R6: With the latch set, block select 00 protects no address, 01 protects 0x600 to 0x7FF, 10 protects 0x400 to 0x7FF and 11 protects all of 0x000 to 0x7FF; a request to a protected address gets `memWrPermit` = 0 and all others get 1.
- R7: With the latch set, a status write is refused only when the lock bit is 1 and `wpPin` is 0.
- R8: A `csRise` strobe clears the latch when a `writeCmdSeen` strobe came earlier in the same selection or in the same cycle; a `csRise` with no such command leaves the latch unchanged.
- R9: A memory-write request with `memBypass` = 1 is always permitted, whatever the latch and the block select.
- R10: Each permit output is 0 in any cycle without its own request strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchSet | input | 1 | Strobe: set the write-enable latch |
| latchClr | input | 1 | Strobe: clear the write-enable latch |
| writeCmdSeen | input | 1 | Strobe: a write-class command was recognised |
| csRise | input | 1 | Strobe: chip select has risen |
| statusWrReq | input | 1 | Strobe: status write request |
| statusWrData | input | 8 | Data byte for the status write |
| memWrReq | input | 1 | Strobe: memory byte write request |
| memWrAddr | input | ADDR_W | Address of the byte being written |
| memBypass | input | 1 | Request belongs to a counter-record command |
| wpPin | input | 1 | Level of the external write-protect pin |
| statusByte | output | 8 | Status byte for read-out |
| memWrPermit | output | 1 | Memory byte may be committed |
| statusWrPermit | output | 1 | Status write may be committed |

## Verification
The block-protect decision is probed with a table that, for each block-select code, places addresses on both sides of the range boundary and at the top and bottom of the array, so an off-by-one or a swapped code is caught. Each table row also loads the status byte with ones in the ignored low data bits and then reads it back, which separates a correct write mask from one that leaks into the latch or bit 0. Directed cases cover the latch with set, clear and both at once; the lock bit against both pin levels; chip-select rises with and without a preceding write-class command; and bypass requests made with the latch clear and the whole array protected.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;

  localparam int STAT_W       = 8;
  localparam int LOCK_POS     = 7;
  localparam int WEL_POS      = 1;
  localparam int BP_HI_POS    = 3;
  localparam int BP_LO_POS    = 2;

  // Bits a status write may change: 7..2.
  localparam logic [STAT_W-1:0] WR_MASK = 8'hFC;

  // Block-select codes.
  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bpCode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wel;
    logic srReq;
    logic memReq;
    logic bypass;
  } ctrlStb_t;

  // Protection test on the two top address bits.
  function automatic logic inGuardedBlock(input logic [1:0] bp, input logic [1:0] topBits);
    logic hit;
    case (bpCode_t'(bp))
      BP_NONE:    hit = 1'b0;
      BP_QUARTER: hit = (topBits == 2'b11);
      BP_HALF:    hit = topBits[1];
      default:    hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/status_guard_ctrl.sv
module status_guard_ctrl
  import status_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     latchSet,
  input  logic     latchClr,
  input  logic     writeCmdSeen,
  input  logic     csRise,
  input  logic     statusWrReq,
  input  logic     memWrReq,
  input  logic     memBypass,
  output ctrlStb_t stb
);

  logic welQ;
  logic pendQ;
  logic welKill;

  // A write-class command ends at the chip-select rise.
  assign welKill = latchClr | (csRise & (pendQ | writeCmdSeen));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (welKill)       welQ <= 1'b0;
      else if (latchSet) welQ <= 1'b1;

      if (csRise)            pendQ <= 1'b0;
      else if (writeCmdSeen) pendQ <= 1'b1;
    end
  end

  always_comb begin
    stb.wel    = welQ;
    stb.srReq  = statusWrReq;
    stb.memReq = memWrReq;
    stb.bypass = memBypass;
  end

endmodule

// File: rtl/status_guard_dp.sv
module status_guard_dp
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [STAT_W-1:0] INIT_STATUS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              wpPin,
  input  logic [STAT_W-1:0] srData,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [STAT_W-1:0] statusByte,
  output logic              memWrPermit,
  output logic              statusWrPermit
);

  localparam int TOP_LO = ADDR_W - 2;

  logic [STAT_W-1:0] nvQ;
  logic [STAT_W-1:0] welImage;
  logic              guarded;
  logic              srLocked;

  assign guarded  = inGuardedBlock(nvQ[BP_HI_POS:BP_LO_POS], memAddr[ADDR_W-1:TOP_LO]);
  assign srLocked = nvQ[LOCK_POS] & ~wpPin;

  always_comb begin
    memWrPermit    = stb.memReq & (stb.bypass | (stb.wel & ~guarded));
    statusWrPermit = stb.srReq & stb.wel & ~srLocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               nvQ <= INIT_STATUS & WR_MASK;
    else if (statusWrPermit) nvQ <= srData & WR_MASK;
  end

  always_comb begin
    welImage          = '0;
    welImage[WEL_POS] = stb.wel;
    statusByte        = (nvQ & WR_MASK) | welImage;
  end

endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchSet,
  input  logic              latchClr,
  input  logic              writeCmdSeen,
  input  logic              csRise,
  input  logic              statusWrReq,
  input  logic [7:0]        statusWrData,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic              memBypass,
  input  logic              wpPin,
  output logic [7:0]        statusByte,
  output logic              memWrPermit,
  output logic              statusWrPermit
);

  ctrlStb_t stb;

  status_guard_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .latchSet     (latchSet),
    .latchClr     (latchClr),
    .writeCmdSeen (writeCmdSeen),
    .csRise       (csRise),
    .statusWrReq  (statusWrReq),
    .memWrReq     (memWrReq),
    .memBypass    (memBypass),
    .stb          (stb)
  );

  status_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wpPin          (wpPin),
    .srData         (statusWrData),
    .memAddr        (memWrAddr),
    .statusByte     (statusByte),
    .memWrPermit    (memWrPermit),
    .statusWrPermit (statusWrPermit)
  );

endmodule

// File: rtl/status_guard_chk.sv
module status_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       latchSet,
  input logic       latchClr,
  input logic       csRise,
  input logic       memWrReq,
  input logic       memBypass,
  input logic       statusWrReq,
  input logic       wpPin,
  input logic [7:0] statusByte,
  input logic       memWrPermit,
  input logic       statusWrPermit
);

  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] == 1'b0); // R1

  AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    latchSet && !latchClr && !csRise |=> statusByte[1]); // R3

  AST_CLR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    latchClr |=> !statusByte[1]); // R3

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !statusWrPermit |=> statusByte[7:2] == $past(statusByte[7:2])); // R4

  AST_NO_LATCH_MEM: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[1] && !memBypass |-> !memWrPermit); // R5

  AST_NO_LATCH_SR: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[1] |-> !statusWrPermit); // R5

  AST_ALL_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:2] == 2'b11 && !memBypass |-> !memWrPermit); // R6

  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] && !wpPin |-> !statusWrPermit); // R7

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && memBypass |-> memWrPermit); // R9

  AST_MEM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !memWrReq |-> !memWrPermit); // R10

  AST_SR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !statusWrReq |-> !statusWrPermit); // R10

endmodule

bind status_guard status_guard_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .latchSet       (latchSet),
  .latchClr       (latchClr),
  .csRise         (csRise),
  .memWrReq       (memWrReq),
  .memBypass      (memBypass),
  .statusWrReq    (statusWrReq),
  .wpPin          (wpPin),
  .statusByte     (statusByte),
  .memWrPermit    (memWrPermit),
  .statusWrPermit (statusWrPermit)
);

// File: tb/sim_status_guard.sv
`timescale 1ns/1ps
module sim_status_guard;

  localparam int ADDR_W = 11;
  localparam int NVEC   = 12;

  // Row: {blockSelect[1:0], address[10:0], expectedPermit}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'b00, 11'h7FF, 1'b1},
    {2'b00, 11'h000, 1'b1},
    {2'b01, 11'h5FF, 1'b1},
    {2'b01, 11'h600, 1'b0},
    {2'b01, 11'h7FF, 1'b0},
    {2'b01, 11'h000, 1'b1},
    {2'b10, 11'h3FF, 1'b1},
    {2'b10, 11'h400, 1'b0},
    {2'b10, 11'h5FF, 1'b0},
    {2'b11, 11'h000, 1'b0},
    {2'b11, 11'h3FF, 1'b0},
    {2'b00, 11'h400, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchSet = 1'b0, latchClr = 1'b0, writeCmdSeen = 1'b0, csRise = 1'b0;
  logic statusWrReq = 1'b0;
  logic [7:0] statusWrData = '0;
  logic memWrReq = 1'b0;
  logic [ADDR_W-1:0] memWrAddr = '0;
  logic memBypass = 1'b0;
  logic wpPin = 1'b1;
  logic [7:0] statusByte;
  logic memWrPermit, statusWrPermit;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  status_guard #(.ADDR_W(ADDR_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wren();
    @(negedge clk); latchSet = 1'b1;
    @(negedge clk); latchSet = 1'b0;
  endtask

  task automatic wrdi();
    @(negedge clk); latchClr = 1'b1;
    @(negedge clk); latchClr = 1'b0;
  endtask

  task automatic wrsr(input logic [7:0] d, output logic permit);
    @(negedge clk); writeCmdSeen = 1'b1;
    @(negedge clk); writeCmdSeen = 1'b0; statusWrReq = 1'b1; statusWrData = d;
    #1 permit = statusWrPermit;
    @(negedge clk); statusWrReq = 1'b0; csRise = 1'b1;
    @(negedge clk); csRise = 1'b0;
  endtask

  task automatic probeMem(input logic [ADDR_W-1:0] a, input logic byp, output logic permit);
    @(negedge clk); memWrReq = 1'b1; memWrAddr = a; memBypass = byp;
    #1 permit = memWrPermit;
    @(negedge clk); memWrReq = 1'b0; memBypass = 1'b0;
  endtask

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(statusByte == 8'h00, "R2", statusByte, 8'h00);
    // R10 no request, no permit
    #1 check(!memWrPermit && !statusWrPermit, "R10", {memWrPermit, statusWrPermit}, 0);

    // R5 latch clear refuses both kinds of write
    probeMem(11'h000, 1'b0, p);
    check(p == 1'b0, "R5 mem", p, 0);
    wrsr(8'hFC, p);
    check(p == 1'b0, "R5 status", p, 0);
    check(statusByte == 8'h00, "R4 refused write keeps byte", statusByte, 8'h00);

    // Table walk: R6 block ranges, R4 mask, R1 layout, R8 latch cleared by WRSR end
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] bp;
      logic [ADDR_W-1:0] a;
      logic e;
      {bp, a, e} = VEC[i];
      wren();
      wrsr({4'b0101, bp, 2'b11}, p);
      check(p == 1'b1, "R7 status write with lock off", p, 1);
      check(statusByte == {4'b0101, bp, 2'b00}, "R4 R1 R8 status after write", statusByte, {4'b0101, bp, 2'b00});
      wren();
      probeMem(a, 1'b0, p);
      check(p == e, "R6 block protect", p, e);
    end

    // R3 set, clear, both
    wren();
    check(statusByte[1] == 1'b1, "R3 set", statusByte[1], 1);
    wrdi();
    check(statusByte[1] == 1'b0, "R3 clear", statusByte[1], 0);
    wren();
    @(negedge clk); latchSet = 1'b1; latchClr = 1'b1;
    @(negedge clk); latchSet = 1'b0; latchClr = 1'b0;
    check(statusByte[1] == 1'b0, "R3 clear wins", statusByte[1], 0);

    // R8 bare csRise keeps latch; csRise after write command clears it
    wren();
    @(negedge clk); csRise = 1'b1;
    @(negedge clk); csRise = 1'b0;
    check(statusByte[1] == 1'b1, "R8 bare csRise", statusByte[1], 1);
    @(negedge clk); writeCmdSeen = 1'b1;
    @(negedge clk); writeCmdSeen = 1'b0;
    @(negedge clk); csRise = 1'b1;
    @(negedge clk); csRise = 1'b0;
    check(statusByte[1] == 1'b0, "R8 write-class end", statusByte[1], 0);

    // R7 lock bit with pin low / high
    wren();
    wrsr(8'h80, p);
    check(statusByte == 8'h80, "R7 lock set", statusByte, 8'h80);
    wpPin = 1'b0;
    wren();
    wrsr(8'h0C, p);
    check(p == 1'b0, "R7 locked refuse", p, 0);
    check(statusByte == 8'h80, "R7 byte kept", statusByte, 8'h80);
    wpPin = 1'b1;
    wren();
    wrsr(8'h8C, p);
    check(p == 1'b1, "R7 pin high allows", p, 1);
    check(statusByte == 8'h8C, "R7 byte loaded", statusByte, 8'h8C);

    // R9 bypass with latch clear and all protected
    probeMem(11'h000, 1'b1, p);
    check(p == 1'b1, "R9 bypass", p, 1);
    probeMem(11'h7FF, 1'b0, p);
    check(p == 1'b0, "R5 no latch after bypass", p, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule